// File: doc/BRIEF.md
# Trace Nibble Packer

The packer sits at the tail of a processor's real-time trace path. Each processor clock it may receive one 4-bit status code from the pipeline. It may also receive a data word to be written out for debug, which is split into nibbles when operand capture is enabled. All nibbles go into a small queue. Every second processor cycle, the two oldest queued nibbles are moved onto an 8-bit output byte. A trace clock at half the processor rate goes with the byte, so an external probe can latch each pair on the trace clock's rising edge.

Nibbles are paired strictly by arrival order. There is no alignment rule, so a status code or any nibble of an operand can sit in either half of a byte. If fewer than two nibbles are queued at a pair boundary, the empty half is filled with an idle code of zero. The trace clock never stops. If the queue overflows, the extra nibbles are dropped and a sticky flag records the loss.

Top module: `trace_nibble_packer`

## Requirements
- R1: While rst_ni is low, pair_o is 8'h00, tclk_o is 0 and ovf_o is 0, and the queue is emptied.
- R2: After reset, tclk_o toggles on every rising clk_i edge. It goes high on the first edge after reset is released.
- R3: pair_o changes only on an edge where tclk_o falls. Each byte is therefore held for two processor cycles and is stable across the rising edge of tclk_o.
- R4: Within a byte, the earlier nibble is in bits 7:4 and the later nibble is in bits 3:0. A run A,B,C,D,E,F on the status input, starting on an edge where tclk_o falls, appears as {A,B}, {C,D} and then {E,F}.
- R5: Pairing depends only on arrival order. An operand nibble may appear in either half of the byte.
- R6: At a pair boundary, a missing nibble is replaced by 4'h0. One queued nibble n gives {n,0}, and an empty queue gives 8'h00. The byte loaded on a falling tclk_o edge holds only nibbles that were queued before that edge.
- R7: A wd_req_i accepted while cap_en_i is high pushes the word's nibbles, least significant first, one per edge on the edges that follow the accepting edge.
- R8: A wd_req_i while cap_en_i is low has no effect on the output stream.
- R9: A wd_req_i that arrives while an earlier word is still being split is ignored.
- R10: If a status nibble and an operand nibble enter on the same edge, the status nibble is earlier in order.
- R11: Nibbles that do not fit in the queue are dropped, the later one of a same-edge pair first. ovf_o then stays high until reset. Space freed by a pop on the same edge is available to that edge's pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_vld_i | input | 1 | Status nibble valid |
| st_nib_i | input | 4 | Status nibble |
| cap_en_i | input | 1 | Operand capture enable |
| wd_req_i | input | 1 | Write-debug-data request |
| wd_data_i | input | WORD_W | Word to be split into nibbles |
| pair_o | output | 8 | Packed nibble pair |
| tclk_o | output | 1 | Half-rate trace clock |
| ovf_o | output | 1 | Sticky queue overflow flag |

## Verification
The bench builds the packer with a 4-entry queue and a 16-bit word, so each write request produces four nibbles. A status nibble and an operand nibble can then be pushed on the same edge and fill the queue within a few cycles. This makes the overflow case reachable: the queue is full, only one slot is free, a pop on the same edge frees space, and the later nibble is dropped. The same settings still cover odd-aligned pairs, idle filling and ignored requests.

// File: rtl/tnp_pkg.sv
package tnp_pkg;
  localparam int unsigned NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;
  localparam nib_t IDLE_NIB = '0;
endpackage

// File: rtl/tnp_opnd_ser.sv
module tnp_opnd_ser
  import tnp_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              cap_en_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              vld_o,
  output nib_t              nib_o
);
  localparam int unsigned NIBS  = WORD_W / NIB_W;
  localparam int unsigned CNT_W = $clog2(NIBS + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              accept;

  assign accept = req_i && cap_en_i && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (accept) begin
      sh_q   <= data_i;
      left_q <= CNT_W'(NIBS);
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> NIB_W;
      left_q <= left_q - 1'b1;
    end
  end

  assign vld_o = (left_q != '0);
  assign nib_o = sh_q[NIB_W-1:0];

  // R9: a busy serializer only counts down
  a_r9_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q > CNT_W'(1)) |=> (left_q == $past(left_q) - 1'b1));
  // R8: disabled capture starts nothing
  a_r8_cap_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && left_q == '0) |=> !vld_o);
endmodule

// File: rtl/tnp_nib_fifo.sv
module tnp_nib_fifo
  import tnp_pkg::*;
#(
  parameter int unsigned DEPTH = 16  // power of two, >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_vld_i,
  input  nib_t a_nib_i,
  input  logic b_vld_i,
  input  nib_t b_nib_i,
  input  logic pop_i,
  output nib_t head0_o,
  output nib_t head1_o,
  output logic have0_o,
  output logic have1_o,
  output logic ovf_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned SUM_W = CNT_W + 1;

  nib_t             mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  logic [1:0]       pop_n, req_n, acc_n;
  logic [SUM_W-1:0] avail;
  logic             drop;
  nib_t             first;

  always_comb begin
    pop_n = '0;
    if (pop_i) pop_n = (cnt_q >= CNT_W'(2)) ? 2'd2 : 2'(cnt_q);
    req_n = 2'(a_vld_i) + 2'(b_vld_i);
    first = a_vld_i ? a_nib_i : b_nib_i;
    avail = SUM_W'(DEPTH) - SUM_W'(cnt_q) + SUM_W'(pop_n);
    drop  = SUM_W'(req_n) > avail;
    acc_n = drop ? 2'(avail) : req_n;
  end

  always_ff @(posedge clk_i) begin
    if (acc_n != 2'd0) mem_q[wr_q] <= first;
    if (acc_n == 2'd2) mem_q[wr_q + PTR_W'(1)] <= b_nib_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_q + PTR_W'(pop_n);
      wr_q  <= wr_q + PTR_W'(acc_n);
      cnt_q <= cnt_q - CNT_W'(pop_n) + CNT_W'(acc_n);
      ovf_q <= ovf_q | drop;
    end
  end

  assign head0_o = mem_q[rd_q];
  assign head1_o = mem_q[rd_q + PTR_W'(1)];
  assign have0_o = (cnt_q != '0);
  assign have1_o = (cnt_q >= CNT_W'(2));
  assign ovf_o   = ovf_q;

  a_r11_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r11_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r11_drop_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_vld_i && b_vld_i && !pop_i && cnt_q == CNT_W'(DEPTH)) |=> ovf_q);
  // R3: occupancy falls only at a pair boundary
  a_r3_pop_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/tnp_pair_out.sv
module tnp_pair_out
  import tnp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       have0_i,
  input  logic       have1_i,
  input  nib_t       head0_i,
  input  nib_t       head1_i,
  output logic       pop_o,
  output logic [7:0] pair_o,
  output logic       tclk_o
);
  logic       ph_q;
  logic [7:0] pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      pair_q <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) pair_q <= {have0_i ? head0_i : IDLE_NIB,
                           have1_i ? head1_i : IDLE_NIB};
    end
  end

  // pop on the edge where the trace clock falls
  assign pop_o  = ph_q;
  assign pair_o = pair_q;
  assign tclk_o = ph_q;

  a_r3_hold_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ph_q |=> $stable(pair_q));
  a_r6_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q && !have0_i) |=> (pair_q == 8'h00));
  a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q && !have1_i) |=> (pair_q[3:0] == IDLE_NIB));
endmodule

// File: rtl/trace_nibble_packer.sv
module trace_nibble_packer
  import tnp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned WORD_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_vld_i,
  input  logic [3:0]        st_nib_i,
  input  logic              cap_en_i,
  input  logic              wd_req_i,
  input  logic [WORD_W-1:0] wd_data_i,
  output logic [7:0]        pair_o,
  output logic              tclk_o,
  output logic              ovf_o
);
  logic op_vld;
  nib_t op_nib;
  logic pop, have0, have1;
  nib_t head0, head1;

  tnp_opnd_ser #(.WORD_W(WORD_W)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(wd_req_i), .cap_en_i(cap_en_i),
    .data_i(wd_data_i), .vld_o(op_vld), .nib_o(op_nib)
  );

  // status is port a: earlier than a same-edge operand nibble
  tnp_nib_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_vld_i(st_vld_i), .a_nib_i(st_nib_i),
    .b_vld_i(op_vld), .b_nib_i(op_nib),
    .pop_i(pop), .head0_o(head0), .head1_o(head1),
    .have0_o(have0), .have1_o(have1), .ovf_o(ovf_o)
  );

  tnp_pair_out u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .have0_i(have0), .have1_i(have1),
    .head0_i(head0), .head1_i(head1), .pop_o(pop),
    .pair_o(pair_o), .tclk_o(tclk_o)
  );
endmodule

// File: tb/sim_trace_nibble_packer.sv
module sim_trace_nibble_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_vld_i = 1'b0;
  logic [3:0]  st_nib_i = '0;
  logic        cap_en_i = 1'b1;
  logic        wd_req_i = 1'b0;
  logic [15:0] wd_data_i = '0;
  logic [7:0]  pair_o;
  logic        tclk_o, ovf_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  trace_nibble_packer #(.FIFO_DEPTH(4), .WORD_W(16)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_vld_i(st_vld_i), .st_nib_i(st_nib_i),
    .cap_en_i(cap_en_i), .wd_req_i(wd_req_i), .wd_data_i(wd_data_i),
    .pair_o(pair_o), .tclk_o(tclk_o), .ovf_o(ovf_o)
  );

  // {status valid, status nibble, expected pair, expected trace clock}
  localparam logic [13:0] VEC [18] = '{
    {1'b0, 4'h0, 8'h00, 1'b1}, {1'b1, 4'hA, 8'h00, 1'b0},
    {1'b1, 4'hB, 8'h00, 1'b1}, {1'b1, 4'hC, 8'hAB, 1'b0},
    {1'b1, 4'hD, 8'hAB, 1'b1}, {1'b1, 4'hE, 8'hCD, 1'b0},
    {1'b1, 4'hF, 8'hCD, 1'b1}, {1'b0, 4'h0, 8'hEF, 1'b0},
    {1'b0, 4'h0, 8'hEF, 1'b1}, {1'b0, 4'h0, 8'h00, 1'b0},
    {1'b1, 4'h1, 8'h00, 1'b1}, {1'b0, 4'h0, 8'h10, 1'b0},
    {1'b1, 4'h2, 8'h10, 1'b1}, {1'b1, 4'h3, 8'h20, 1'b0},
    {1'b1, 4'h4, 8'h20, 1'b1}, {1'b0, 4'h0, 8'h34, 1'b0},
    {1'b0, 4'h0, 8'h34, 1'b1}, {1'b0, 4'h0, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic v, input logic [3:0] n, input logic rq,
                      input logic [15:0] d);
    st_vld_i = v; st_nib_i = n; wd_req_i = rq; wd_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    st_vld_i = 1'b0; wd_req_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; st_vld_i = 1'b0; wd_req_i = 1'b0; cap_en_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 pair", pair_o, 8'h00);
    chk("R1 tclk", {7'd0, tclk_o}, 8'h00);
    chk("R1 ovf", {7'd0, ovf_o}, 8'h00);
    rst_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // table: status stream, R2 clock, R3 hold, R4 ordering, R5/R6 odd start
    for (int i = 0; i < 18; i++) begin
      tick(VEC[i][13], VEC[i][12:9], 1'b0, 16'h0);
      chk("R2 tclk", {7'd0, tclk_o}, {7'd0, VEC[i][0]});
      if (i % 2 == 0)  chk("R3 hold", pair_o, VEC[i][8:1]);
      else if (i < 9)  chk("R4 pair", pair_o, VEC[i][8:1]);
      else             chk("R6 pair", pair_o, VEC[i][8:1]);
    end

    // R7 R10 R5: operand split, status first on shared edge
    do_reset();
    tick(1'b0, 4'h0, 1'b1, 16'h4321);
    tick(1'b1, 4'hA, 1'b0, 16'h0);
    chk("R6 empty", pair_o, 8'h00);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R10 order", pair_o, 8'hA1);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R5 operand upper", pair_o, 8'h23);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R7 last nibble", pair_o, 8'h40);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R7 drained", pair_o, 8'h00);

    // R8: capture disabled
    do_reset();
    cap_en_i = 1'b0;
    tick(1'b0, 4'h0, 1'b1, 16'h4321);
    for (int k = 0; k < 3; k++) tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R8 ignored a", pair_o, 8'h00);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R8 ignored b", pair_o, 8'h00);
    cap_en_i = 1'b1;

    // R9: request while busy
    do_reset();
    tick(1'b0, 4'h0, 1'b1, 16'h4321);
    tick(1'b0, 4'h0, 1'b1, 16'h8765);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R9 first", pair_o, 8'h12);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R9 second", pair_o, 8'h34);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R9 no reload", pair_o, 8'h00);

    // R11: overflow with one free slot and same-edge pop space
    do_reset();
    tick(1'b1, 4'h5, 1'b1, 16'h4321);
    tick(1'b1, 4'h6, 1'b0, 16'h0);
    chk("R11 first pair", pair_o, 8'h50);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b1, 4'h8, 1'b0, 16'h0);
    chk("R11 pair", pair_o, 8'h61);
    chk("R11 pop space", {7'd0, ovf_o}, 8'h00);
    tick(1'b1, 4'h9, 1'b0, 16'h0);
    chk("R11 flag set", {7'd0, ovf_o}, 8'h01);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R11 pair b", pair_o, 8'h28);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R11 later dropped", pair_o, 8'h39);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    tick(1'b0, 4'h0, 1'b0, 16'h0);
    chk("R11 drained", pair_o, 8'h00);
    chk("R11 sticky", {7'd0, ovf_o}, 8'h01);

    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule